// File: doc/BRIEF.md
# Exception Entry Sequencer

This block holds the control state that a RISC core changes when it takes an exception or an interrupt. That state is the program counter and its prefetch successor, the status register, the vector base, the saved-context registers, the cause registers, the trap-argument register and the general-register file with its two switchable low halves. The core still owns the normal program flow. On an ordinary cycle it writes the PC, SR, vector base, flags and general registers through plain write ports.

When a synchronous exception request (general fault, translation miss or trap) or an external interrupt request arrives, the block does the whole entry in a single clock edge. It saves the old PC, the old merged status word and R15. It records the cause code in the exception-cause or interrupt-cause register. It jumps to the vector base plus a fixed offset for that class. It raises the privilege, block and bank-select status bits. Setting bank-select changes which copy of R0–R7 is visible from the next cycle on. The condition flags T, S, M and Q are stored outside the status word and are merged into it whenever the status word is read.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset, pc_o = 0xA0000000, npc_o = 0xA0000002, vbr_o = 0, fpscr_o = 0x00040001, expevt_o = 0 (power-on cause), intevt_o = 0, tra_o = 0, sr_o = 0, in_slot_o = 0, and every general register reads 0.
- R2: An accepted event loads pc_o with vbr_o plus an offset that depends on its class. The offset is 0x100 for exc_kind 0 (general) or 3 (treated as general). It is 0x400 for exc_kind 1 (translation miss), 0x100 for exc_kind 2 (trap), and 0x600 for an interrupt. npc_o becomes the new pc_o + 2.
- R3: On any accepted event, spc_o takes the old pc_o, ssr_o takes the old sr_o (flags merged), and sgr_o takes the old value of R15.
- R4: After any accepted event, sr_o equals the old sr_o with bit 30 (privileged), bit 28 (block) and bit 29 (bank select) set.
- R5: A general or translation-miss exception writes exc_code to expevt_o. If in_slot_o is 1 it writes exc_slot_code instead. Any accepted exception clears in_slot_o, and intevt_o does not change.
- R6: A trap writes {trap_imm, 2'b00}, zero-extended, to tra_o. It writes the fixed trap cause 0x160 to expevt_o whatever in_slot_o is, and clears in_slot_o.
- R7: An accepted interrupt writes irq_code to intevt_o. expevt_o, tra_o and in_slot_o do not change.
- R8: One event is accepted per cycle, and an exception wins over an interrupt raised in the same cycle. In a cycle that accepts an event, every core-side write (pc, sr, flags, vbr, general register, slot_set) is ignored.
- R9: Register addresses 0–7 reach the copy selected by SR bit 29, as that bit stood at the start of the cycle. Addresses 8–15 reach one shared copy. So changing bit 29 by an SR write or by an event exchanges all eight low registers at once.
- R10: The flags T, S, Q and M appear at sr_o bits 0, 1, 8 and 9. flag_wdata bit 0 is T, bit 1 is S, bit 2 is M and bit 3 is Q. A flag write overrides the flags taken from an SR write in the same cycle.
- R11: A PC write sets pc_o to pc_wdata and npc_o to pc_wdata + 2. npc_o always equals pc_o + 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| exc_valid | input | 1 | Synchronous exception request |
| exc_kind | input | 2 | 0 general, 1 translation miss, 2 trap, 3 general |
| exc_code | input | CODE_W | Cause code for a fault outside a delay slot |
| exc_slot_code | input | CODE_W | Cause code for a fault inside a delay slot |
| trap_imm | input | 8 | Trap immediate |
| irq_valid | input | 1 | Interrupt request |
| irq_code | input | CODE_W | Interrupt cause code |
| slot_set | input | 1 | Marks that the next instruction sits in a delay slot |
| pc_we | input | 1 | PC write enable |
| pc_wdata | input | XLEN | PC write value |
| sr_we | input | 1 | SR write enable |
| sr_wdata | input | XLEN | SR write value, flags included |
| flag_we | input | 1 | Flag write enable |
| flag_wdata | input | 4 | {Q, M, S, T} |
| vbr_we | input | 1 | Vector base write enable |
| vbr_wdata | input | XLEN | Vector base write value |
| gpr_we | input | 1 | General register write enable |
| gpr_waddr | input | AW | General register write address |
| gpr_wdata | input | XLEN | General register write value |
| gpr_raddr | input | AW | General register read address |
| pc_o | output | XLEN | Program counter |
| npc_o | output | XLEN | Next program counter |
| sr_o | output | XLEN | Status word with flags merged |
| ssr_o | output | XLEN | Saved status |
| spc_o | output | XLEN | Saved PC |
| sgr_o | output | XLEN | Saved R15 |
| vbr_o | output | XLEN | Vector base |
| fpscr_o | output | XLEN | Floating-point control word (reset value only) |
| expevt_o | output | CODE_W | Exception cause |
| intevt_o | output | CODE_W | Interrupt cause |
| tra_o | output | XLEN | Trap argument |
| in_slot_o | output | 1 | Delay-slot flag |
| gpr_rdata | output | XLEN | General register read data (combinational) |

## Verification
The hardest case to reach from the ports is a fault taken while the delay-slot flag is set. It needs a slot_set cycle first, then an exception of each kind, and the trap case has to ignore the slot code. A close second is the bank exchange: the low registers must be filled in both copies before bit 29 flips, or the exchange cannot be told apart from a plain write. The bench drives both cases directly: a slot-then-fault pair for each kind, and bank fills with reads before and after SR writes and after event entries. After that, seeded random cycles mix simultaneous events with concurrent core writes and are compared against a reference model held in the bench.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

    typedef enum logic [1:0] {
        EV_GENERAL = 2'd0,
        EV_TLB     = 2'd1,
        EV_TRAP    = 2'd2,
        EV_ALT     = 2'd3
    } ev_kind_e;

    // Status word bit positions that other logic decodes
    localparam int SR_T_BIT  = 0;
    localparam int SR_S_BIT  = 1;
    localparam int SR_Q_BIT  = 8;
    localparam int SR_M_BIT  = 9;
    localparam int SR_BL_BIT = 28;
    localparam int SR_RB_BIT = 29;
    localparam int SR_MD_BIT = 30;

endpackage

// File: rtl/exc_vector_calc.sv
module exc_vector_calc
    import exc_seq_pkg::*;
#(
    parameter int          XLEN      = 32,
    parameter int          CODE_W    = 12,
    parameter int unsigned OFS_GEN   = 'h100,
    parameter int unsigned OFS_TLB   = 'h400,
    parameter int unsigned OFS_IRQ   = 'h600,
    parameter int unsigned TRAP_CODE = 'h160
) (
    input  logic              exc_valid,
    input  logic [1:0]        exc_kind,
    input  logic [CODE_W-1:0] exc_code,
    input  logic [CODE_W-1:0] exc_slot_code,
    input  logic              in_slot,
    input  logic              irq_valid,
    input  logic [CODE_W-1:0] irq_code,
    input  logic [XLEN-1:0]   vbr,
    output logic              take,
    output logic              take_irq,
    output logic              take_trap,
    output logic [XLEN-1:0]   target,
    output logic [CODE_W-1:0] code
);

    logic [CODE_W-1:0] fault_code;

    assign fault_code = in_slot ? exc_slot_code : exc_code;

    always_comb begin
        take      = 1'b0;
        take_irq  = 1'b0;
        take_trap = 1'b0;
        target    = vbr;
        code      = '0;
        if (exc_valid) begin
            take = 1'b1;
            unique case (ev_kind_e'(exc_kind))
                EV_TLB: begin
                    target = vbr + XLEN'(OFS_TLB);
                    code   = fault_code;
                end
                EV_TRAP: begin
                    take_trap = 1'b1;
                    target    = vbr + XLEN'(OFS_GEN);
                    code      = CODE_W'(TRAP_CODE);
                end
                default: begin
                    target = vbr + XLEN'(OFS_GEN);
                    code   = fault_code;
                end
            endcase
        end else if (irq_valid) begin
            take     = 1'b1;
            take_irq = 1'b1;
            target   = vbr + XLEN'(OFS_IRQ);
            code     = irq_code;
        end
    end

endmodule

// File: rtl/exc_gpr_bank.sv
module exc_gpr_bank #(
    parameter int XLEN = 32,
    parameter int NLO  = 8,
    parameter int NHI  = 8,
    localparam int NREG = NLO + NHI,
    localparam int AW   = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  logic [XLEN-1:0] wdata,
    input  logic            rb,
    input  logic [AW-1:0]   raddr,
    output logic [XLEN-1:0] rdata,
    output logic [XLEN-1:0] r_top
);

    logic [XLEN-1:0] vis [NREG];

    // Low registers: two copies each, picked by the bank-select bit
    for (genvar g = 0; g < NLO; g++) begin : g_lo
        logic [XLEN-1:0] b0_q, b1_q;
        logic [XLEN-1:0] b0_d, b1_d;
        logic            hit;

        assign hit = we && (waddr == AW'(g));

        always_comb begin
            b0_d = b0_q;
            b1_d = b1_q;
            if (hit && !rb) b0_d = wdata;
            if (hit &&  rb) b1_d = wdata;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                b0_q <= '0;
                b1_q <= '0;
            end else begin
                b0_q <= b0_d;
                b1_q <= b1_d;
            end
        end

        assign vis[g] = rb ? b1_q : b0_q;
    end

    // High registers: one shared copy
    for (genvar g = 0; g < NHI; g++) begin : g_hi
        logic [XLEN-1:0] h_q, h_d;

        assign h_d = (we && (waddr == AW'(NLO + g))) ? wdata : h_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) h_q <= '0;
            else        h_q <= h_d;
        end

        assign vis[NLO + g] = h_q;
    end

    assign rdata = vis[raddr];
    assign r_top = vis[NREG-1];

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_seq_pkg::*;
#(
    parameter int          XLEN         = 32,
    parameter int          CODE_W       = 12,
    parameter int          NLO          = 8,
    parameter int          NHI          = 8,
    parameter int unsigned OFS_GEN      = 'h100,
    parameter int unsigned OFS_TLB      = 'h400,
    parameter int unsigned OFS_IRQ      = 'h600,
    parameter int unsigned TRAP_CODE    = 'h160,
    parameter int unsigned RESET_PC     = 'hA000_0000,
    parameter int unsigned RESET_FPSCR  = 'h0004_0001,
    parameter int unsigned RESET_EXPEVT = 'h000,
    localparam int AW = $clog2(NLO + NHI)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_valid,
    input  logic [1:0]        exc_kind,
    input  logic [CODE_W-1:0] exc_code,
    input  logic [CODE_W-1:0] exc_slot_code,
    input  logic [7:0]        trap_imm,
    input  logic              irq_valid,
    input  logic [CODE_W-1:0] irq_code,
    input  logic              slot_set,
    input  logic              pc_we,
    input  logic [XLEN-1:0]   pc_wdata,
    input  logic              sr_we,
    input  logic [XLEN-1:0]   sr_wdata,
    input  logic              flag_we,
    input  logic [3:0]        flag_wdata,
    input  logic              vbr_we,
    input  logic [XLEN-1:0]   vbr_wdata,
    input  logic              gpr_we,
    input  logic [AW-1:0]     gpr_waddr,
    input  logic [XLEN-1:0]   gpr_wdata,
    input  logic [AW-1:0]     gpr_raddr,
    output logic [XLEN-1:0]   pc_o,
    output logic [XLEN-1:0]   npc_o,
    output logic [XLEN-1:0]   sr_o,
    output logic [XLEN-1:0]   ssr_o,
    output logic [XLEN-1:0]   spc_o,
    output logic [XLEN-1:0]   sgr_o,
    output logic [XLEN-1:0]   vbr_o,
    output logic [XLEN-1:0]   fpscr_o,
    output logic [CODE_W-1:0] expevt_o,
    output logic [CODE_W-1:0] intevt_o,
    output logic [XLEN-1:0]   tra_o,
    output logic              in_slot_o,
    output logic [XLEN-1:0]   gpr_rdata
);

    localparam logic [XLEN-1:0] FLAG_MASK = XLEN'((1 << SR_T_BIT) | (1 << SR_S_BIT) |
                                                  (1 << SR_Q_BIT) | (1 << SR_M_BIT));
    localparam logic [XLEN-1:0] ENTRY_SET = XLEN'((1 << SR_MD_BIT) | (1 << SR_BL_BIT) |
                                                  (1 << SR_RB_BIT));

    // flg bit 0 T, 1 S, 2 M, 3 Q; sr holds the status word with flag bits at zero
    typedef struct packed {
        logic [XLEN-1:0]   pc;
        logic [XLEN-1:0]   npc;
        logic [XLEN-1:0]   vbr;
        logic [XLEN-1:0]   fpscr;
        logic [XLEN-1:0]   sr;
        logic [3:0]        flg;
        logic [XLEN-1:0]   ssr;
        logic [XLEN-1:0]   spc;
        logic [XLEN-1:0]   sgr;
        logic [XLEN-1:0]   tra;
        logic [CODE_W-1:0] expevt;
        logic [CODE_W-1:0] intevt;
        logic              slot;
    } seq_state_t;

    seq_state_t st_q, st_d;

    logic              take, take_irq, take_trap;
    logic [XLEN-1:0]   target;
    logic [CODE_W-1:0] code;
    logic [XLEN-1:0]   sr_rd;
    logic [XLEN-1:0]   r15;

    exc_vector_calc #(
        .XLEN(XLEN), .CODE_W(CODE_W), .OFS_GEN(OFS_GEN), .OFS_TLB(OFS_TLB),
        .OFS_IRQ(OFS_IRQ), .TRAP_CODE(TRAP_CODE)
    ) u_vec (
        .exc_valid    (exc_valid),
        .exc_kind     (exc_kind),
        .exc_code     (exc_code),
        .exc_slot_code(exc_slot_code),
        .in_slot      (st_q.slot),
        .irq_valid    (irq_valid),
        .irq_code     (irq_code),
        .vbr          (st_q.vbr),
        .take         (take),
        .take_irq     (take_irq),
        .take_trap    (take_trap),
        .target       (target),
        .code         (code)
    );

    exc_gpr_bank #(
        .XLEN(XLEN), .NLO(NLO), .NHI(NHI)
    ) u_gpr (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (gpr_we && !take),
        .waddr(gpr_waddr),
        .wdata(gpr_wdata),
        .rb   (st_q.sr[SR_RB_BIT]),
        .raddr(gpr_raddr),
        .rdata(gpr_rdata),
        .r_top(r15)
    );

    // Merge the separately held flags into the visible status word
    always_comb begin
        sr_rd            = st_q.sr;
        sr_rd[SR_T_BIT]  = st_q.flg[0];
        sr_rd[SR_S_BIT]  = st_q.flg[1];
        sr_rd[SR_M_BIT]  = st_q.flg[2];
        sr_rd[SR_Q_BIT]  = st_q.flg[3];
    end

    always_comb begin
        st_d = st_q;
        if (take) begin
            st_d.spc = st_q.pc;
            st_d.ssr = sr_rd;
            st_d.sgr = r15;
            st_d.pc  = target;
            st_d.npc = target + XLEN'(2);
            st_d.sr  = (sr_rd | ENTRY_SET) & ~FLAG_MASK;
            if (take_irq) begin
                st_d.intevt = code;
            end else begin
                st_d.expevt = code;
                st_d.slot   = 1'b0;
            end
            if (take_trap) begin
                st_d.tra = XLEN'({trap_imm, 2'b00});
            end
        end else begin
            if (pc_we) begin
                st_d.pc  = pc_wdata;
                st_d.npc = pc_wdata + XLEN'(2);
            end
            if (sr_we) begin
                st_d.sr  = sr_wdata & ~FLAG_MASK;
                st_d.flg = {sr_wdata[SR_Q_BIT], sr_wdata[SR_M_BIT],
                            sr_wdata[SR_S_BIT], sr_wdata[SR_T_BIT]};
            end
            if (flag_we) begin
                st_d.flg = flag_wdata;
            end
            if (vbr_we) begin
                st_d.vbr = vbr_wdata;
            end
            if (slot_set) begin
                st_d.slot = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.pc     <= XLEN'(RESET_PC);
            st_q.npc    <= XLEN'(RESET_PC) + XLEN'(2);
            st_q.fpscr  <= XLEN'(RESET_FPSCR);
            st_q.expevt <= CODE_W'(RESET_EXPEVT);
        end else begin
            st_q <= st_d;
        end
    end

    assign pc_o      = st_q.pc;
    assign npc_o     = st_q.npc;
    assign sr_o      = sr_rd;
    assign ssr_o     = st_q.ssr;
    assign spc_o     = st_q.spc;
    assign sgr_o     = st_q.sgr;
    assign vbr_o     = st_q.vbr;
    assign fpscr_o   = st_q.fpscr;
    assign expevt_o  = st_q.expevt;
    assign intevt_o  = st_q.intevt;
    assign tra_o     = st_q.tra;
    assign in_slot_o = st_q.slot;

endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk
    import exc_seq_pkg::*;
#(
    parameter int          XLEN    = 32,
    parameter int          CODE_W  = 12,
    parameter int unsigned OFS_IRQ = 'h600
) (
    input logic              clk,
    input logic              rst_n,
    input logic              exc_valid,
    input logic [1:0]        exc_kind,
    input logic [7:0]        trap_imm,
    input logic              irq_valid,
    input logic              pc_we,
    input logic [XLEN-1:0]   pc_o,
    input logic [XLEN-1:0]   npc_o,
    input logic [XLEN-1:0]   sr_o,
    input logic [XLEN-1:0]   spc_o,
    input logic [XLEN-1:0]   vbr_o,
    input logic [CODE_W-1:0] expevt_o,
    input logic [CODE_W-1:0] intevt_o,
    input logic [XLEN-1:0]   tra_o
);

    a_r11_npc_ahead: assert property (@(posedge clk) disable iff (!rst_n)
        npc_o == pc_o + XLEN'(2));

    a_r3_spc_saved: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid || irq_valid) |=> spc_o == $past(pc_o));

    a_r4_entry_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid || irq_valid) |=> (sr_o[SR_MD_BIT] && sr_o[SR_BL_BIT] && sr_o[SR_RB_BIT]));

    a_r2_irq_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && !exc_valid) |=> pc_o == $past(vbr_o) + XLEN'(OFS_IRQ));

    a_r7_irq_keeps_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && !exc_valid) |=> $stable(expevt_o));

    a_r8_exc_wins: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |=> $stable(intevt_o));

    a_r8_pc_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && pc_we) |=> spc_o == $past(pc_o));

    a_r6_trap_arg: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && exc_kind == 2'd2) |=> tra_o == XLEN'({$past(trap_imm), 2'b00}));

endmodule

bind exc_entry_seq exc_entry_seq_chk #(
    .XLEN(XLEN), .CODE_W(CODE_W), .OFS_IRQ(OFS_IRQ)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .exc_valid(exc_valid),
    .exc_kind (exc_kind),
    .trap_imm (trap_imm),
    .irq_valid(irq_valid),
    .pc_we    (pc_we),
    .pc_o     (pc_o),
    .npc_o    (npc_o),
    .sr_o     (sr_o),
    .spc_o    (spc_o),
    .vbr_o    (vbr_o),
    .expevt_o (expevt_o),
    .intevt_o (intevt_o),
    .tra_o    (tra_o)
);

// File: tb/exc_entry_seq_test.sv
`timescale 1ns/1ps
module exc_entry_seq_test;

    localparam int XLEN = 32;
    localparam int CW   = 12;
    localparam int AW   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic            exc_valid = 0, irq_valid = 0, slot_set = 0;
    logic [1:0]      exc_kind = 0;
    logic [CW-1:0]   exc_code = 0, exc_slot_code = 0, irq_code = 0;
    logic [7:0]      trap_imm = 0;
    logic            pc_we = 0, sr_we = 0, flag_we = 0, vbr_we = 0, gpr_we = 0;
    logic [XLEN-1:0] pc_wdata = 0, sr_wdata = 0, vbr_wdata = 0, gpr_wdata = 0;
    logic [3:0]      flag_wdata = 0;
    logic [AW-1:0]   gpr_waddr = 0, gpr_raddr = 0;

    logic [XLEN-1:0] pc_o, npc_o, sr_o, ssr_o, spc_o, sgr_o, vbr_o, fpscr_o, tra_o, gpr_rdata;
    logic [CW-1:0]   expevt_o, intevt_o;
    logic            in_slot_o;

    exc_entry_seq uut (.*);

    int unsigned n_chk = 0, n_err = 0;
    bit done = 0;

    // Reference model
    logic [XLEN-1:0] m_pc, m_npc, m_sr, m_ssr, m_spc, m_sgr, m_vbr, m_tra;
    logic [3:0]      m_flg;
    logic [CW-1:0]   m_exp, m_int;
    logic            m_slot;
    logic [XLEN-1:0] m_lo0 [8], m_lo1 [8], m_hi [8];

    function automatic logic [XLEN-1:0] m_merged();
        logic [XLEN-1:0] v = m_sr;
        v[0] = m_flg[0]; v[1] = m_flg[1]; v[9] = m_flg[2]; v[8] = m_flg[3];
        return v;
    endfunction

    function automatic logic [XLEN-1:0] m_read(int a);
        if (a >= 8) return m_hi[a-8];
        return m_sr[29] ? m_lo1[a] : m_lo0[a];
    endfunction

    task automatic m_reset();
        m_pc = 32'hA000_0000; m_npc = 32'hA000_0002; m_sr = 0; m_flg = 0;
        m_ssr = 0; m_spc = 0; m_sgr = 0; m_vbr = 0; m_tra = 0;
        m_exp = 0; m_int = 0; m_slot = 0;
        for (int i = 0; i < 8; i++) begin m_lo0[i] = 0; m_lo1[i] = 0; m_hi[i] = 0; end
    endtask

    task automatic m_step();
        logic [XLEN-1:0] ms, vec;
        logic [CW-1:0] cd;
        if (exc_valid || irq_valid) begin
            ms = m_merged();
            m_spc = m_pc; m_ssr = ms; m_sgr = m_read(15);
            if (exc_valid) begin
                cd = m_slot ? exc_slot_code : exc_code;
                vec = 32'h100;
                if (exc_kind == 2'd1) vec = 32'h400;
                if (exc_kind == 2'd2) begin cd = 12'h160; m_tra = {22'd0, trap_imm, 2'b00}; end
                m_exp = cd; m_slot = 0;
            end else begin
                vec = 32'h600; m_int = irq_code;
            end
            m_pc = m_vbr + vec; m_npc = m_pc + 2;
            m_sr = (ms | 32'h7000_0000) & ~32'h0000_0303;
        end else begin
            if (gpr_we) begin
                if (gpr_waddr >= 8) m_hi[gpr_waddr-8] = gpr_wdata;
                else if (m_sr[29]) m_lo1[gpr_waddr] = gpr_wdata;
                else m_lo0[gpr_waddr] = gpr_wdata;
            end
            if (pc_we) begin m_pc = pc_wdata; m_npc = pc_wdata + 2; end
            if (sr_we) begin
                m_sr = sr_wdata & ~32'h0000_0303;
                m_flg = {sr_wdata[8], sr_wdata[9], sr_wdata[1], sr_wdata[0]};
            end
            if (flag_we) m_flg = flag_wdata;
            if (vbr_we) m_vbr = vbr_wdata;
            if (slot_set) m_slot = 1;
        end
    endtask

    task automatic chk(string tag, logic [XLEN-1:0] got, logic [XLEN-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic compare(string sc);
        chk({sc, " R2/R11 pc"}, pc_o, m_pc);
        chk({sc, " R11 npc"}, npc_o, m_npc);
        chk({sc, " R4/R10 sr"}, sr_o, m_merged());
        chk({sc, " R3 ssr"}, ssr_o, m_ssr);
        chk({sc, " R3 spc"}, spc_o, m_spc);
        chk({sc, " R3 sgr"}, sgr_o, m_sgr);
        chk({sc, " R8 vbr"}, vbr_o, m_vbr);
        chk({sc, " R5 expevt"}, {20'd0, expevt_o}, {20'd0, m_exp});
        chk({sc, " R7 intevt"}, {20'd0, intevt_o}, {20'd0, m_int});
        chk({sc, " R6 tra"}, tra_o, m_tra);
        chk({sc, " R5 slot"}, {31'd0, in_slot_o}, {31'd0, m_slot});
        chk({sc, " R9 gpr"}, gpr_rdata, m_read(int'(gpr_raddr)));
    endtask

    task automatic idle();
        exc_valid = 0; irq_valid = 0; slot_set = 0; pc_we = 0; sr_we = 0;
        flag_we = 0; vbr_we = 0; gpr_we = 0;
    endtask

    task automatic tick(string sc);
        @(posedge clk);
        m_step();
        @(negedge clk);
        compare(sc);
        idle();
    endtask

    task automatic wr_gpr(int a, logic [XLEN-1:0] v);
        gpr_we = 1; gpr_waddr = AW'(a); gpr_wdata = v; tick("R9 fill");
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        m_reset();
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        compare("R1 in reset");
        chk("R1 fpscr", fpscr_o, 32'h0004_0001);
        rst_n = 1;
        @(negedge clk);
        compare("R1 after reset");

        // R11 pc write, R8 vbr write
        pc_we = 1; pc_wdata = 32'h0000_1000; vbr_we = 1; vbr_wdata = 32'h8C00_0000;
        tick("R11 pc write");

        // R10 flags
        flag_we = 1; flag_wdata = 4'b1111; tick("R10 flags all");
        sr_we = 1; sr_wdata = 32'h0000_0201; flag_we = 1; flag_wdata = 4'b0010;
        tick("R10 flag overrides sr");
        sr_we = 1; sr_wdata = 32'h0000_0102; tick("R10 sr loads flags");

        // R9 bank contents in both copies
        wr_gpr(0, 32'h0000_00A0); wr_gpr(7, 32'h0000_00A7); wr_gpr(15, 32'h0000_0F15);
        gpr_raddr = 0; sr_we = 1; sr_wdata = 32'h2000_0000; tick("R9 switch to bank 1");
        wr_gpr(0, 32'h0000_00B0);
        gpr_raddr = 0; sr_we = 1; sr_wdata = 32'h0; tick("R9 back to bank 0");
        gpr_raddr = 15; tick("R9 shared high");

        // R2/R3/R4/R5 general exception; entry sets bank 1
        gpr_raddr = 0; exc_valid = 1; exc_kind = 2'd0; exc_code = 12'h0E0;
        exc_slot_code = 12'h1A0; tick("R2 general exception");
        gpr_raddr = 7; tick("R9 after entry");

        // R5 delay-slot fault, translation miss
        sr_we = 1; sr_wdata = 0; pc_we = 1; pc_wdata = 32'h0000_2000; tick("prep");
        slot_set = 1; tick("R5 slot set");
        exc_valid = 1; exc_kind = 2'd1; exc_code = 12'h040; exc_slot_code = 12'h1C0;
        tick("R5 slot tlb exception");
        // R6 trap in slot ignores slot code
        slot_set = 1; tick("R6 slot set");
        exc_valid = 1; exc_kind = 2'd2; trap_imm = 8'hFF; tick("R6 trap in slot");
        exc_valid = 1; exc_kind = 2'd3; exc_code = 12'h180; tick("R2 kind 3 general");

        // R7 interrupt
        slot_set = 1; tick("R7 slot set");
        irq_valid = 1; irq_code = 12'h320; tick("R7 interrupt");

        // R8 both events with core writes in the same cycle
        exc_valid = 1; exc_kind = 2'd0; exc_code = 12'h0A0; irq_valid = 1; irq_code = 12'h3C0;
        pc_we = 1; pc_wdata = 32'h5555_0000; gpr_we = 1; gpr_waddr = 4'd15; gpr_wdata = 32'hDEAD;
        vbr_we = 1; vbr_wdata = 32'h1; flag_we = 1; flag_wdata = 4'hF; sr_we = 1; sr_wdata = 0;
        gpr_raddr = 15; tick("R8 both plus writes");
        irq_valid = 1; irq_code = 12'h340; slot_set = 1; pc_we = 1; pc_wdata = 32'h7;
        tick("R8 irq drops writes");

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            exc_valid     = ($urandom % 8) == 0;
            irq_valid     = ($urandom % 8) == 0;
            exc_kind      = 2'($urandom);
            exc_code      = CW'($urandom);
            exc_slot_code = CW'($urandom);
            irq_code      = CW'($urandom);
            trap_imm      = 8'($urandom);
            slot_set      = ($urandom % 6) == 0;
            pc_we         = ($urandom % 4) == 0;
            pc_wdata      = $urandom;
            sr_we         = ($urandom % 6) == 0;
            sr_wdata      = $urandom;
            flag_we       = ($urandom % 6) == 0;
            flag_wdata    = 4'($urandom);
            vbr_we        = ($urandom % 10) == 0;
            vbr_wdata     = $urandom;
            gpr_we        = ($urandom % 2) == 0;
            gpr_waddr     = AW'($urandom);
            gpr_wdata     = $urandom;
            gpr_raddr     = AW'($urandom);
            tick("random R1-mix");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule